// File: doc/BRIEF.md
# Boundary Scan Test Access Logic

This block is the test access port of a chip: a serial test interface clocked by its own test clock, with a mode-select line, a serial input, a serial output with its own enable, and an asynchronous active-low test reset. A sixteen-state controller follows the mode-select line. It steers shifts through either a 4-bit instruction register or one of three data registers. The data registers are a one-stage bypass, a fixed 32-bit identification code and a chain of 16 boundary cells.

Each boundary cell sits on one functional signal path, between the core and a pad. It can observe the path by capturing the value arriving at the cell. It can also control the path by driving its destination from an update latch. Cells come in three kinds: input cells (pad to core), output cells (core to pad), and output-enable cells, which are output cells carrying a pad's drive enable. Parameter masks set the kind of each cell. The current instruction decides whether each path runs functionally or is driven from the latches. The test interface is serial and has no back-pressure, so every port is a plain signal.

Top module: `tap_scan_top`

## Requirements
- R1: The controller changes state only on a rising `test_clk`, as the 1149.1 state graph directs from `mode_sel`. Five consecutive rising edges with `mode_sel` high reach Test-Logic-Reset from any state, and that state restores the IDCODE instruction.
- R2: `test_rst_n` low at once forces Test-Logic-Reset, loads the IDCODE instruction, clears every boundary update latch and drives `scan_out_en` low, without a clock edge.
- R3: The 4-bit instruction register shifts in from `scan_in`, least significant bit first. Capture-IR loads 4'b0001, so the first bits out are 1,0,0,0. A shifted value becomes the current instruction only in Update-IR, not during Shift-IR or Pause-IR.
- R4: Opcodes are EXTEST 4'h0, IDCODE 4'h1, SAMPLE 4'h2, INTEST 4'h3, CLAMP 4'h4, HIGHZ 4'h5 and BYPASS 4'hF. Any other opcode behaves as BYPASS.
- R5: Under IDCODE the data register captures 32'h1224C02B and shifts it out least significant bit first. The fields are version [31:28]=1, part [27:12]=16'h224C, maker [11:1]=11'h015 and bit 0 = 1.
- R6: BYPASS, CLAMP, HIGHZ and unassigned opcodes select a single-stage register. It captures 0, so a Shift-DR gives 0 followed by `scan_in` delayed by one clock.
- R7: EXTEST, SAMPLE and INTEST select the boundary chain. Capture-DR loads each cell with its `cell_src` bit. Cell 0 is nearest `scan_out`, and `scan_in` enters at cell 15.
- R8: The update latches take the chain contents at the falling edge in Update-DR, and only while the boundary chain is selected. Scans of other registers leave them unchanged.
- R9: Under IDCODE, SAMPLE and BYPASS, every `cell_dst` bit equals its `cell_src` bit. This also holds while a SAMPLE scan is in progress.
- R10: Under EXTEST and CLAMP, output-kind cells (mask bit set, default 16'hFFF0, cells 4 to 15) drive `cell_dst` from their update latch. Input cells (0 to 3) pass `cell_src`.
- R11: Under INTEST, input cells drive `cell_dst` from their update latch, and output-kind cells pass `cell_src`.
- R12: Under HIGHZ, output-enable cells (default mask 16'hC000, cells 14 and 15) drive `cell_dst` low. All other cells pass `cell_src`.
- R13: `scan_out` changes only on a falling `test_clk`. `scan_out_en` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| mode_sel | input | 1 | Controller steering line, sampled on rising `test_clk` |
| scan_in | input | 1 | Serial data into the selected register |
| scan_out | output | 1 | Serial data out, updated on falling `test_clk` |
| scan_out_en | output | 1 | High while `scan_out` is driven (shift states) |
| cell_src | input | 16 | Value arriving at each boundary cell from its functional source |
| cell_dst | output | 16 | Value each boundary cell passes to its functional destination |

## Verification
The assertions assume that `test_rst_n` is low before the first rising `test_clk`, and that `mode_sel`, `scan_in` and `cell_src` never change at a rising edge. They also assume that the enable-cell mask lies inside the output-kind mask. The bench holds reset from time zero. It moves every input one nanosecond after a falling edge, so each value is stable at the next rising edge and at the falling edge where latches update. It releases reset only at that same point in the cycle.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'h0,
    ST_IDLE     = 4'h1,
    ST_DR_SEL   = 4'h2,
    ST_DR_CAP   = 4'h3,
    ST_DR_SHIFT = 4'h4,
    ST_DR_EXIT1 = 4'h5,
    ST_DR_PAUSE = 4'h6,
    ST_DR_EXIT2 = 4'h7,
    ST_DR_UPD   = 4'h8,
    ST_IR_SEL   = 4'h9,
    ST_IR_CAP   = 4'hA,
    ST_IR_SHIFT = 4'hB,
    ST_IR_EXIT1 = 4'hC,
    ST_IR_PAUSE = 4'hD,
    ST_IR_EXIT2 = 4'hE,
    ST_IR_UPD   = 4'hF
  } tap_state_e;

  localparam int OP_W = 4;
  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST = 4'h0;
  localparam opcode_t OP_IDCODE = 4'h1;
  localparam opcode_t OP_SAMPLE = 4'h2;
  localparam opcode_t OP_INTEST = 4'h3;
  localparam opcode_t OP_CLAMP  = 4'h4;
  localparam opcode_t OP_HIGHZ  = 4'h5;
  localparam opcode_t OP_BYPASS = 4'hF;
  localparam opcode_t IR_CAPTURE_VAL = 4'b0001;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDENT    = 2'd1,
    DR_BOUNDARY = 2'd2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;       // which data register sits between scan_in and scan_out
    logic    pad_ctl;  // output-kind cells driven from update latches
    logic    core_ctl; // input cells driven from update latches
    logic    hiz;      // enable cells forced off
  } decode_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm import tap_scan_pkg::*; (
  input  logic       test_clk,
  input  logic       test_rst_n,
  input  logic       mode_sel,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = mode_sel ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = mode_sel ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = mode_sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = mode_sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = mode_sel ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = mode_sel ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = mode_sel ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = mode_sel ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = mode_sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = mode_sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = mode_sel ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = mode_sel ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = mode_sel ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = mode_sel ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  // R1: transitions on the rising test clock only; R2: asynchronous reset
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) state <= ST_RESET;
    else             state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir import tap_scan_pkg::*; #(
  parameter int      W       = OP_W,
  parameter opcode_t CAP_VAL = IR_CAPTURE_VAL,
  parameter opcode_t RST_OP  = OP_IDCODE
) (
  input  logic       test_clk,
  input  logic       test_rst_n,
  input  logic       scan_in,
  input  tap_state_e state,
  output logic       ir_so,
  output opcode_t    ir_cur
);

  opcode_t shreg;

  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)                shreg <= '0;
    else if (state == ST_IR_CAP)    shreg <= CAP_VAL;
    else if (state == ST_IR_SHIFT)  shreg <= {scan_in, shreg[W-1:1]};
  end

  // R3: the instruction takes effect only at the falling edge in Update-IR
  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)               ir_cur <= RST_OP;
    else if (state == ST_RESET)    ir_cur <= RST_OP;
    else if (state == ST_IR_UPD)   ir_cur <= shreg;
  end

  assign ir_so = shreg[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode import tap_scan_pkg::*; (
  input  opcode_t op,
  output decode_t dec
);

  // R4: any code not listed falls through to the bypass behaviour
  always_comb begin
    dec = '{dr: DR_BYPASS, pad_ctl: 1'b0, core_ctl: 1'b0, hiz: 1'b0};
    case (op)
      OP_EXTEST: begin dec.dr = DR_BOUNDARY; dec.pad_ctl = 1'b1; end
      OP_IDCODE: dec.dr = DR_IDENT;
      OP_SAMPLE: dec.dr = DR_BOUNDARY;
      OP_INTEST: begin dec.dr = DR_BOUNDARY; dec.core_ctl = 1'b1; end
      OP_CLAMP:  dec.pad_ctl = 1'b1;
      OP_HIGHZ:  dec.hiz = 1'b1;
      default:   dec.dr = DR_BYPASS;
    endcase
  end

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr import tap_scan_pkg::*; #(
  parameter int             CELLS    = 16,
  parameter logic [CELLS-1:0] OUT_MASK = 16'hFFF0,
  parameter logic [CELLS-1:0] EN_MASK  = 16'hC000
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  tap_state_e       state,
  input  logic             sel,
  input  logic             pad_ctl,
  input  logic             core_ctl,
  input  logic             hiz,
  input  logic             scan_in,
  output logic             bsr_so,
  input  logic [CELLS-1:0] cell_src,
  output logic [CELLS-1:0] cell_dst,
  output logic [CELLS-1:0] upd_state
);

  logic [CELLS:0] chain;
  assign chain[CELLS] = scan_in;   // R7: serial input enters the top cell

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic cap_q;
    logic upd_q;

    always_ff @(posedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n) cap_q <= 1'b0;
      else if (sel) begin
        if (state == ST_DR_CAP)        cap_q <= cell_src[i];
        else if (state == ST_DR_SHIFT) cap_q <= chain[i+1];
      end
    end

    // R8: latches load on the falling edge of Update-DR with the chain selected
    always_ff @(negedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n)                      upd_q <= 1'b0;
      else if (sel && state == ST_DR_UPD)   upd_q <= cap_q;
    end

    assign chain[i]     = cap_q;
    assign upd_state[i] = upd_q;

    if (OUT_MASK[i]) begin : g_out
      // R10, R12: core-to-pad cell
      assign cell_dst[i] = pad_ctl ? upd_q :
                           (hiz && EN_MASK[i]) ? 1'b0 : cell_src[i];
    end else begin : g_in
      // R11: pad-to-core cell
      assign cell_dst[i] = core_ctl ? upd_q : cell_src[i];
    end
  end

  assign bsr_so = chain[0];

endmodule

// File: rtl/tap_scan_top.sv
module tap_scan_top import tap_scan_pkg::*; #(
  parameter int               CELLS      = 16,
  parameter int               ID_W       = 32,
  parameter logic [3:0]       ID_VERSION = 4'h1,
  parameter logic [15:0]      ID_PART    = 16'h224C,
  parameter logic [10:0]      ID_MAKER   = 11'h015,
  parameter logic [CELLS-1:0] OUT_MASK   = 16'hFFF0,
  parameter logic [CELLS-1:0] EN_MASK    = 16'hC000
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  logic             mode_sel,
  input  logic             scan_in,
  output logic             scan_out,
  output logic             scan_out_en,
  input  logic [CELLS-1:0] cell_src,
  output logic [CELLS-1:0] cell_dst
);

  // R5: identification value assembled from its fields
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_e       state;
  opcode_t          ir_cur;
  logic             ir_so;
  decode_t          dec;
  logic             bsr_so;
  logic             bsr_sel;
  logic [CELLS-1:0] upd_state;
  logic             byp_q;
  logic [ID_W-1:0]  id_sr;
  logic             dr_so;

  tap_fsm u_fsm (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .mode_sel   (mode_sel),
    .state      (state)
  );

  tap_ir u_ir (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .scan_in    (scan_in),
    .state      (state),
    .ir_so      (ir_so),
    .ir_cur     (ir_cur)
  );

  tap_decode u_dec (
    .op  (ir_cur),
    .dec (dec)
  );

  assign bsr_sel = (dec.dr == DR_BOUNDARY);

  tap_bsr #(
    .CELLS    (CELLS),
    .OUT_MASK (OUT_MASK),
    .EN_MASK  (EN_MASK)
  ) u_bsr (
    .test_clk   (test_clk),
    .test_rst_n (test_rst_n),
    .state      (state),
    .sel        (bsr_sel),
    .pad_ctl    (dec.pad_ctl),
    .core_ctl   (dec.core_ctl),
    .hiz        (dec.hiz),
    .scan_in    (scan_in),
    .bsr_so     (bsr_so),
    .cell_src   (cell_src),
    .cell_dst   (cell_dst),
    .upd_state  (upd_state)
  );

  // R6: single-stage bypass, captures zero
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) byp_q <= 1'b0;
    else if (dec.dr == DR_BYPASS) begin
      if (state == ST_DR_CAP)        byp_q <= 1'b0;
      else if (state == ST_DR_SHIFT) byp_q <= scan_in;
    end
  end

  // R5: identification shift register
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) id_sr <= '0;
    else if (dec.dr == DR_IDENT) begin
      if (state == ST_DR_CAP)        id_sr <= ID_VALUE;
      else if (state == ST_DR_SHIFT) id_sr <= {scan_in, id_sr[ID_W-1:1]};
    end
  end

  always_comb begin
    case (dec.dr)
      DR_IDENT:    dr_so = id_sr[0];
      DR_BOUNDARY: dr_so = bsr_so;
      default:     dr_so = byp_q;
    endcase
  end

  // R13: serial output and its enable move on the falling edge
  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      scan_out    <= 1'b0;
      scan_out_en <= 1'b0;
    end else begin
      scan_out_en <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
      scan_out    <= (state == ST_IR_SHIFT) ? ir_so :
                     (state == ST_DR_SHIFT) ? dr_so : 1'b0;
    end
  end

endmodule

// File: rtl/tap_scan_chk.sv
module tap_scan_chk import tap_scan_pkg::*; #(
  parameter int               CELLS   = 16,
  parameter logic [CELLS-1:0] EN_MASK = 16'hC000
) (
  input logic             test_clk,
  input logic             test_rst_n,
  input logic             mode_sel,
  input tap_state_e       state,
  input opcode_t          ir_cur,
  input logic             scan_out_en,
  input logic [CELLS-1:0] cell_src,
  input logic [CELLS-1:0] cell_dst,
  input logic [CELLS-1:0] upd_state
);

  p_five_high_reset_r1: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (mode_sel && $past(mode_sel) && $past(mode_sel, 2) && $past(mode_sel, 3) && $past(mode_sel, 4))
    |=> (state == ST_RESET));

  p_ir_hold_in_shift_r3: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    ((state == ST_IR_SHIFT) && ($past(state) == ST_IR_SHIFT)) |-> $stable(ir_cur));

  p_latch_hold_r8: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (state != ST_DR_UPD) |-> $stable(upd_state));

  p_functional_path_r9: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    ((ir_cur == OP_IDCODE) || (ir_cur == OP_SAMPLE) || (ir_cur == OP_BYPASS))
    |-> (cell_dst == cell_src));

  p_enables_off_r12: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (ir_cur == OP_HIGHZ) |-> ((cell_dst & EN_MASK) == '0));

  p_out_en_shift_r13: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    scan_out_en == ((state == ST_IR_SHIFT) || (state == ST_DR_SHIFT)));

endmodule

bind tap_scan_top tap_scan_chk #(
  .CELLS   (CELLS),
  .EN_MASK (EN_MASK)
) u_chk (
  .test_clk    (test_clk),
  .test_rst_n  (test_rst_n),
  .mode_sel    (mode_sel),
  .state       (state),
  .ir_cur      (ir_cur),
  .scan_out_en (scan_out_en),
  .cell_src    (cell_src),
  .cell_dst    (cell_dst),
  .upd_state   (upd_state)
);

// File: tb/tap_scan_top_test.sv
`timescale 1ns/1ps
module tap_scan_top_test;

  localparam logic [15:0] OUTM = 16'hFFF0;
  localparam logic [15:0] ENM  = 16'hC000;
  localparam logic [31:0] IDV  = 32'h1224C02B;

  logic        test_clk = 1'b0;
  logic        test_rst_n = 1'b0;
  logic        tms_r = 1'b1;
  logic        tdi_r = 1'b0;
  logic        scan_out, scan_out_en;
  logic [15:0] src = 16'h0000;
  logic [15:0] dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #2.5 test_clk = ~test_clk;

  tap_scan_top uut (
    .test_clk    (test_clk),
    .test_rst_n  (test_rst_n),
    .mode_sel    (tms_r),
    .scan_in     (tdi_r),
    .scan_out    (scan_out),
    .scan_out_en (scan_out_en),
    .cell_src    (src),
    .cell_dst    (dst)
  );

  // Monitor: pops one expected serial bit per rising edge while items wait
  always @(posedge test_clk) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (scan_out !== e || scan_out_en !== 1'b1) begin
        errors++;
        $display("FAIL %s: scan_out=%b en=%b expected %b en=1", t, scan_out, scan_out_en, e);
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Every task starts and ends one nanosecond after a falling edge
  task automatic step(input logic m, input logic d);
    tms_r = m;
    tdi_r = d;
    @(posedge test_clk);
    @(negedge test_clk);
    #1;
  endtask

  task automatic step_exp(input logic m, input logic d, input logic e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    step(m, d);
  endtask

  // Idle -> DR scan of n bits -> Idle
  task automatic scan_dr(input logic [31:0] din, input int n, input logic [31:0] exp,
                         input bit chk, input string tag);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      if (chk) step_exp(i == n - 1, din[i], exp[i], tag);
      else     step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  // Idle -> IR load, checking the captured pattern (R3) -> Idle
  task automatic load_ir(input logic [3:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step_exp(i == 3, op[i], (i == 0), "R3 capture");
    step(1, 0); step(0, 0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge test_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  localparam logic WALK_TMS [23] = '{0,1,0,0,1,0,1,0,1,1,1,1,0,0,1,0,1,0,1,1,1,1,1};
  localparam logic WALK_EN  [23] = '{0,0,0,1,0,0,0,1,0,0,0,0,0,1,0,0,0,1,0,0,0,0,0};

  initial begin
    logic [15:0] a, b, c, d;
    src = 16'hA5C3;
    repeat (3) @(negedge test_clk);
    #1;
    // R2 reset state
    check(scan_out_en, 0, "R2 reset out_en");
    check(dst, src, "R2 reset functional path");
    test_rst_n = 1'b1;
    step(1, 0);
    step(0, 0);

    // R5 identification read after reset
    scan_dr(32'h0, 32, IDV, 1, "R5 idcode");

    // R1/R13 walk through all sixteen states (scan_in high)
    step(1, 1); step(1, 1); step(1, 1); step(1, 1); step(1, 1);
    for (int i = 0; i < 23; i++) begin
      step(WALK_TMS[i], 1'b1);
      check(scan_out_en, WALK_EN[i], $sformatf("R13 walk step %0d", i));
    end
    check(dst, src, "R1 walk ends in reset, functional");
    step(0, 0);

    // R3 instruction held through Pause-IR, then EXTEST applied (R10)
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step_exp(i == 3, 1'b0, (i == 0), "R3 capture");
    step(0, 0);                                   // Pause-IR
    check(dst, src, "R3 no effect before Update-IR");
    step(1, 0); step(1, 0); step(0, 0);
    check(dst, src & ~OUTM, "R10 EXTEST cleared latches");

    // R1 five high cycles return to reset and IDCODE
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    check(dst, src, "R1 five-high reset");
    step(0, 0);

    // R6 bypass one-stage delay
    load_ir(4'hF);
    scan_dr(32'hB2, 8, (32'hB2 << 1) & 32'hFF, 1, "R6 bypass");
    // R4 unassigned opcode behaves as bypass
    load_ir(4'hA);
    scan_dr(32'h6D, 8, (32'h6D << 1) & 32'hFF, 1, "R4 unassigned");
    check(dst, src, "R4 unassigned functional path");

    // R7/R9 SAMPLE captures the sources, leaves the path alone, preloads latches
    a = 16'h3C5A; b = 16'hF00D;
    src = a;
    load_ir(4'h2);
    scan_dr({16'h0, b}, 16, {16'h0, a}, 1, "R7 sample capture");
    check(dst, src, "R9 sample functional path");

    // R10 EXTEST drives output cells from preloaded latches (R8)
    load_ir(4'h0);
    check(dst, (b & OUTM) | (src & ~OUTM), "R10 extest drive");
    c = 16'h9669; d = 16'h1234;
    src = c;
    scan_dr({16'h0, d}, 16, {16'h0, c}, 1, "R7 extest capture");
    check(dst, (d & OUTM) | (c & ~OUTM), "R8 extest update");

    // R11 INTEST drives input cells from the latches
    load_ir(4'h3);
    check(dst, (d & ~OUTM) | (c & OUTM), "R11 intest drive");

    // R10 CLAMP keeps pads from latches with bypass selected (R6), latches untouched (R8)
    load_ir(4'h4);
    check(dst, (d & OUTM) | (c & ~OUTM), "R10 clamp drive");
    scan_dr(32'hB, 4, (32'hB << 1) & 32'hF, 1, "R6 clamp bypass");
    check(dst, (d & OUTM) | (c & ~OUTM), "R8 clamp latches kept");

    // R12 HIGHZ forces enable cells low
    load_ir(4'h5);
    check(dst, c & ~ENM, "R12 highz enables off");

    // R13 scan_out moves on the falling edge only (bypass captured 0, shifting 1)
    step(1, 0); step(0, 0); step(0, 0);
    check(scan_out_en, 1, "R13 out_en in Shift-DR");
    tms_r = 0; tdi_r = 1;
    @(posedge test_clk); #1;
    check(scan_out, 0, "R13 holds after rising edge");
    @(negedge test_clk); #1;
    check(scan_out, 1, "R13 changes on falling edge");

    // R2 asynchronous reset in the middle of a shift
    test_rst_n = 1'b0;
    #1;
    check(scan_out_en, 0, "R2 async out_en");
    check(dst, src, "R2 async instruction IDCODE");
    tms_r = 1;
    @(negedge test_clk); #1;
    test_rst_n = 1'b1;
    step(0, 0);
    load_ir(4'h0);
    check(dst, src & ~OUTM, "R2 latches cleared");

    done = 1'b1;
    while (exp_q.size() > 0) @(negedge test_clk);
    summary();
    $finish;
  end

endmodule